// File: doc/BRIEF.md
# Automatic Sleep Controller for a Memory Read Interface

This block decides, with no host command, when a memory read interface may go into a low-power sleep state. It also keeps the last read data on its output while the interface sleeps. The rule for entering sleep depends on the interface mode.

- **Asynchronous mode:** the block counts system clock cycles during which the address has not changed. An address change wakes the interface at once, and fresh read data is captured again.
- **Synchronous burst mode:** the block watches the interface clock after each burst start. Sleep is entered if the first high level lasts too long, or if the clock runs too slowly. Once asleep in this mode, only a new burst start brings the interface back.

The interface clock is asynchronous to the system clock, so it is brought in through a two-stage synchronizer. Its edges are then detected on the system clock. All three thresholds are parameters counted in system clock cycles:

- `ADDR_STABLE_CYC`: the address-stable time (access time plus margin).
- `FIRST_LVL_CYC`: the longest allowed first clock level.
- `PERIOD_LIMIT_CYC`: the longest allowed interface clock period (200 ns worth of cycles).

Top module: `auto_sleep_ctrl`

## Requirements
- R1: In asynchronous mode (`sync_mode`=0), `sleep` rises exactly `ADDR_STABLE_CYC` rising clock edges after the edge that first samples a new address, and is 0 before that.
- R2: In asynchronous mode, an address change seen at a clock edge clears `sleep` after that edge. `dout` then returns `rd_data` from the following edge on.
- R3: In asynchronous mode, with the address held, the stability count saturates and `sleep` stays 1 for as long as the address is unchanged.
- R4: While `sleep` is 1, `dout` keeps its value whatever `rd_data` does. While `sleep` is 0, `dout` equals `rd_data` sampled at the previous clock edge.
- R5: In synchronous mode (`sync_mode`=1), after a `burst_start` pulse, a first synchronized high level of `if_clk` lasting at least `FIRST_LVL_CYC` cycles sets `sleep`. A shorter first high level does not.
- R6: In synchronous mode, only the first high level after a burst start is timed. Later long high levels do not set `sleep`.
- R7: In synchronous mode, if the spacing between rising edges of `if_clk` (or the time since the burst start or since the last rising edge) exceeds `PERIOD_LIMIT_CYC` cycles, `sleep` is set. This includes a stopped `if_clk`.
- R8: In synchronous mode, `sleep` stays 1 until a `burst_start` pulse, which clears it at the next edge. Address changes do not wake the interface.
- R9: During and right after reset, `sleep` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = synchronous burst mode, 0 = asynchronous mode |
| addr | input | AW | Address bus of the memory interface |
| if_clk | input | 1 | Interface clock of the burst mode (asynchronous to `clk`) |
| burst_start | input | 1 | One-cycle strobe marking the start of a new burst |
| rd_data | input | DW | Read data from the memory array |
| sleep | output | 1 | Interface is in the sleep state |
| dout | output | DW | Output data, held while asleep |

## Verification
The hardest situation to reach is the boundary of the slow-clock detector. The detector must not fire when rising edges come exactly `PERIOD_LIMIT_CYC` cycles apart, and must fire at one cycle more. The high level must stay short all the while, so that the first-level timer cannot be what raises `sleep`. The bench drives `if_clk` with a two-cycle high pulse and a variable low time, and sweeps the period across the limit over several consecutive periods. The first-level limit is swept in the same way, with the synchronizer's two-cycle delay taken into account when choosing the sampling points.

// File: rtl/auto_sleep_ctrl.sv
module auto_sleep_ctrl #(
  parameter int DW               = 16,
  parameter int AW               = 20,
  parameter int ADDR_STABLE_CYC  = 16,
  parameter int FIRST_LVL_CYC    = 12,
  parameter int PERIOD_LIMIT_CYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic [AW-1:0] addr,
  input  logic          if_clk,
  input  logic          burst_start,
  input  logic [DW-1:0] rd_data,
  output logic          sleep,
  output logic [DW-1:0] dout
);
  localparam int SW = $clog2(ADDR_STABLE_CYC + 1);
  localparam int FW = $clog2(FIRST_LVL_CYC + 1);
  localparam int PW = $clog2(PERIOD_LIMIT_CYC + 1);
  localparam logic [SW-1:0] S_TH = SW'(ADDR_STABLE_CYC);
  localparam logic [FW-1:0] F_TH = FW'(FIRST_LVL_CYC);
  localparam logic [PW-1:0] P_TH = PW'(PERIOD_LIMIT_CYC);

  logic [AW-1:0] addr_q;
  logic [SW-1:0] stab_cnt;
  logic [FW-1:0] hi_cnt;
  logic [PW-1:0] per_cnt;
  logic [2:0]    ck_sy;
  logic          first_pend, sync_sleep;

  wire addr_chg = addr != addr_q;
  wire lvl      = ck_sy[1];
  wire rise     = ck_sy[1] & ~ck_sy[2];
  wire fall     = ~ck_sy[1] & ck_sy[2];

  assign sleep = sync_mode ? sync_sleep : (stab_cnt == S_TH);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q   <= '0;
      stab_cnt <= '0;
    end else begin
      addr_q <= addr;
      if (addr_chg)            stab_cnt <= '0;
      else if (stab_cnt != S_TH) stab_cnt <= stab_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sy      <= '0;
      hi_cnt     <= '0;
      per_cnt    <= '0;
      first_pend <= 1'b0;
      sync_sleep <= 1'b0;
    end else begin
      ck_sy <= {ck_sy[1:0], if_clk};

      if (burst_start || !lvl)  hi_cnt <= '0;
      else if (hi_cnt != F_TH)  hi_cnt <= hi_cnt + 1'b1;

      if (burst_start || rise)  per_cnt <= '0;
      else if (per_cnt != P_TH) per_cnt <= per_cnt + 1'b1;

      if (burst_start) first_pend <= 1'b1;
      else if (fall)   first_pend <= 1'b0;

      if (!sync_mode || burst_start)
        sync_sleep <= 1'b0;
      else if ((first_pend && hi_cnt == F_TH) || per_cnt == P_TH)
        sync_sleep <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dout <= '0;
    else if (!sleep) dout <= rd_data;
endmodule

module auto_sleep_ctrl_chk #(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_mode,
  input logic [AW-1:0] addr,
  input logic          burst_start,
  input logic [DW-1:0] rd_data,
  input logic          sleep,
  input logic [DW-1:0] dout
);
  a_r2_addr_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !$stable(addr)) |=> (sync_mode || !sleep));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dout));

  a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> dout == $past(rd_data));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && sleep && !burst_start) |=> (!sync_mode || sleep));

  a_r8_burst_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && burst_start) |=> (!sync_mode || !sleep));

  always_comb
    if (!rst_n) a_r9_reset: assert (!sleep && dout == '0);
endmodule

bind auto_sleep_ctrl auto_sleep_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .addr(addr),
  .burst_start(burst_start), .rd_data(rd_data), .sleep(sleep), .dout(dout)
);

// File: tb/test_auto_sleep_ctrl.sv
module test_auto_sleep_ctrl;
  localparam int DW = 16, AW = 8, TH = 6, FL = 8, PL = 20;

  logic clk = 0, rst_n = 0, sync_mode = 0, if_clk = 0, burst_start = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] rd_data = '0;
  logic sleep;
  logic [DW-1:0] dout;
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] held;

  always #2.5 clk = ~clk;

  auto_sleep_ctrl #(.DW(DW), .AW(AW), .ADDR_STABLE_CYC(TH),
                    .FIRST_LVL_CYC(FL), .PERIOD_LIMIT_CYC(PL)) i_auto_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .addr(addr), .if_clk(if_clk),
    .burst_start(burst_start), .rd_data(rd_data), .sleep(sleep), .dout(dout));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic burst();
    burst_start = 1; cyc(1); burst_start = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R9 sleep", sleep, 0);
    check("R9 dout", dout, 0);
    cyc(2); rst_n = 1; @(negedge clk);

    // R1/R3: stability sweep
    for (int d = 0; d <= TH + 3; d++) begin
      addr = AW'(d + 1);
      cyc(1);
      if (d > 0) cyc(d);
      check("R1 stable sweep", sleep, (d >= TH));
    end
    cyc(50);
    check("R3 saturated", sleep, 1);

    // R4: hold while asleep
    held = dout;
    for (int i = 0; i < 8; i++) begin
      rd_data = DW'(16'h1234 + i * 16'h0101);
      cyc(1);
      check("R4 held", dout, held);
    end
    // R2: wake on address change
    addr = addr + 1'b1; rd_data = 16'hBEEF;
    cyc(1);
    check("R2 awake", sleep, 0);
    check("R2 held one edge", dout, held);
    cyc(1);
    check("R2 new data", dout, 16'hBEEF);
    // R4: follow while awake
    for (int i = 0; i < TH - 2; i++) begin
      rd_data = DW'(i * 16'h0F0F + 3);
      cyc(1);
      check("R4 follow", dout, DW'(i * 16'h0F0F + 3));
    end

    // synchronous mode
    sync_mode = 1;
    for (int h = FL - 3; h <= FL + 3; h++) begin
      burst();
      check("R8 burst wakes", sleep, 0);
      if_clk = 1; cyc(h);
      if_clk = 0; cyc(6);
      check("R5 first level", sleep, (h >= FL));
    end
    // now asleep (last h >= FL): address and data changes do not wake
    held = dout;
    addr = addr + 1'b1; rd_data = 16'h5A5A;
    cyc(3);
    check("R8 addr ignored", sleep, 1);
    check("R4 held sync", dout, held);
    burst();
    check("R8 burst clears", sleep, 0);
    cyc(1);
    check("R4 new data sync", dout, 16'h5A5A);

    // R6: second long level not timed
    burst();
    if_clk = 1; cyc(3); if_clk = 0; cyc(3);
    if_clk = 1; cyc(FL + 3); if_clk = 0; cyc(3);
    check("R6 later level", sleep, 0);

    // R7: period sweep across the limit
    for (int p = PL - 2; p <= PL + 2; p++) begin
      burst();
      for (int k = 0; k < 3; k++) begin
        if_clk = 1; cyc(2);
        if_clk = 0; cyc(p - 2);
      end
      check("R7 period sweep", sleep, (p > PL));
    end
    burst();
    cyc(PL + 5);
    check("R7 stopped clock", sleep, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule